// File: doc/BRIEF.md
# Serial Transmitter with Post-Character Guard Gap

This block serialises characters onto an asynchronous, idle-high transmit line. A single-entry holding register accepts a character from the host side and hands it to the shifter as soon as the shifter is free. The host can therefore queue the next character while the current one is still on the wire. Every frame is one low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Each bit lasts one period of an external bit tick.

After each stop bit the block can keep the line high for a programmable number of extra bit periods. This guard gap gives slow receivers time to recover between characters. Two registered flags tell the host what it may do. The ready flag means a new character will be accepted. The empty flag means the line has returned to rest, with the guard gap included. Separate enable and disable commands start and stop the transmitter. A pending break request holds off new characters. Shaping the break waveform and generating the baud tick belong to other logic.

Top module: `guarded_uart_tx`

## Requirements
- R1: While reset is high and after it is released, `txd` is 1, `txrdy` is 0 and `txempty` is 0 until an enable command arrives.
- R2: An enable command (`tx_en_cmd` high for one cycle) given while the transmitter is disabled sets `txrdy` and `txempty` to 1 on the next cycle, provided no break is pending.
- R3: A frame starts with one low start bit. It then sends the data bits least significant first. Every bit lasts from one bit tick to the next.
- R4: `par_mode` selects the parity bit sent after the data: 2'b00 none, 2'b01 even (data bits plus parity hold an even count of ones), 2'b10 odd, 2'b11 none.
- R5: The stop bit is 1. When `guard_len` is nonzero, the line then stays 1 for exactly `guard_len` further bit periods. When it is 0 there is no gap.
- R6: `txempty` is 0 while a character sits in the holding register or the shifter. It rises at the tick that ends the stop bit, or at the tick that ends the guard gap when `guard_len` is nonzero.
- R7: `txrdy` is 0 while the holding register is full, and 0 one cycle after `brk_pend` goes high. It is 1 when the transmitter is enabled, the holding register is empty and no break is pending.
- R8: A write (`wr_valid`) while `txrdy` is 0 is discarded. No extra frame is sent and the held character is unchanged.
- R9: A disable command drops any held or shifting character. On the next cycle `txd` is 1 and both flags are 0. Disable wins over a simultaneous enable.
- R10: `len_code` selects 5, 6, 7 or 8 data bits (codes 0 to 3). A shorter character uses the low bits of `wr_data`, and the upper bits are ignored.
- R11: A character queued during a frame has its start bit begin at the tick that ends the previous stop bit (guard 0), with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send, right-aligned |
| len_code | input | 2 | Data length: 5 + code bits |
| par_mode | input | 2 | Parity selection |
| guard_len | input | 8 | Guard gap in bit periods, 0 disables |
| tx_en_cmd | input | 1 | Enable command pulse |
| tx_dis_cmd | input | 1 | Disable command pulse |
| brk_pend | input | 1 | Break request pending (level) |
| txd | output | 1 | Serial output line, idle high |
| txrdy | output | 1 | Holding register can take a character |
| txempty | output | 1 | Line at rest, guard gap done |

## Verification
The hardest state to reach from the ports is a full holding register while the shifter is busy. Only in that state does a write get refused and a back-to-back frame follow. The bench slows the bit tick to one pulse every eight clocks. It then waits for the first start bit and writes two more characters within that start bit. The second of these finds the holding register occupied. The bench then follows both frames bit by bit. It requires the second start bit to come at the tick that ends the first stop bit, and the line to stay idle afterwards, which shows the refused character never went out. A disable issued in the middle of a frame checks the abort path in the same way.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int TXG_DW = 8;
  localparam int TXG_GW = 8;

  typedef enum logic [2:0] {
    FR_IDLE  = 3'd0,
    FR_START = 3'd1,
    FR_DATA  = 3'd2,
    FR_PAR   = 3'd3,
    FR_STOP  = 3'd4,
    FR_GUARD = 3'd5
  } fr_state_e;

  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;
endpackage

// File: rtl/txg_hold.sv
module txg_hold #(
  parameter int DW = txg_pkg::TXG_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dis,
  input  logic          wr_ok,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    len_code,
  input  logic          take,
  output logic          full_q,
  output logic          full_n,
  output logic [DW-1:0] data_q
);
  localparam int BASE = DW - 3;

  logic [DW-1:0] keep;

  for (genvar i = 0; i < DW; i++) begin : g_keep
    assign keep[i] = (int'(len_code) + BASE) > i;
  end

  always_comb begin
    if (dis)        full_n = 1'b0;
    else if (wr_ok) full_n = 1'b1;
    else if (take)  full_n = 1'b0;
    else            full_n = full_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_n;
      if (wr_ok) data_q <= wr_data & keep;
    end
  end
endmodule

// File: rtl/txg_framer.sv
module txg_framer
  import txg_pkg::*;
#(
  parameter int DW = TXG_DW,
  parameter int GW = TXG_GW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dis,
  input  logic          tick,
  input  logic          en_q,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic [1:0]    len_code,
  input  logic [1:0]    par_mode,
  input  logic [GW-1:0] guard,
  output logic          take,
  output logic          idle_n,
  output logic          txd_q,
  output fr_state_e     state_q
);
  localparam int IW = $clog2(DW);

  fr_state_e     state_n;
  logic [IW-1:0] idx_q, idx_n, last_idx;
  logic [GW-1:0] gcnt_q, gcnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          par_q, par_n, txd_n, next_char, par_on;

  assign last_idx = IW'(DW - 4) + IW'(len_code);
  assign par_on   = (par_mode == PM_EVEN) || (par_mode == PM_ODD);
  assign idle_n   = (state_n == FR_IDLE);

  always_comb begin
    state_n   = state_q;
    idx_n     = idx_q;
    gcnt_n    = gcnt_q;
    sh_n      = sh_q;
    par_n     = par_q;
    txd_n     = txd_q;
    take      = 1'b0;
    next_char = 1'b0;
    if (dis) begin
      state_n = FR_IDLE;
      txd_n   = 1'b1;
    end else if (tick) begin
      case (state_q)
        FR_IDLE: next_char = 1'b1;
        FR_START, FR_DATA: begin
          if (state_q == FR_DATA && idx_q == last_idx) begin
            state_n = par_on ? FR_PAR : FR_STOP;
            txd_n   = par_on ? par_q : 1'b1;
          end else begin
            idx_n   = (state_q == FR_START) ? '0 : idx_q + 1'b1;
            state_n = FR_DATA;
            txd_n   = sh_q[0];
            sh_n    = {1'b0, sh_q[DW-1:1]};
          end
        end
        FR_PAR: begin
          state_n = FR_STOP;
          txd_n   = 1'b1;
        end
        FR_STOP: begin
          if (guard != '0) begin
            state_n = FR_GUARD;
            gcnt_n  = GW'(1);
            txd_n   = 1'b1;
          end else begin
            next_char = 1'b1;
          end
        end
        FR_GUARD: begin
          if (gcnt_q >= guard) next_char = 1'b1;
          else                 gcnt_n = gcnt_q + 1'b1;
        end
        default: state_n = FR_IDLE;
      endcase
      if (next_char) begin
        if (hold_full && en_q) begin
          take    = 1'b1;
          sh_n    = hold_data;
          par_n   = (^hold_data) ^ (par_mode == PM_ODD);
          state_n = FR_START;
          txd_n   = 1'b0;
        end else begin
          state_n = FR_IDLE;
          txd_n   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_IDLE;
      idx_q   <= '0;
      gcnt_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      gcnt_q  <= gcnt_n;
      sh_q    <= sh_n;
      par_q   <= par_n;
      txd_q   <= txd_n;
    end
  end
endmodule

// File: rtl/guarded_uart_tx.sv
module guarded_uart_tx
  import txg_pkg::*;
#(
  parameter int DW = TXG_DW,
  parameter int GW = TXG_GW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    len_code,
  input  logic [1:0]    par_mode,
  input  logic [GW-1:0] guard_len,
  input  logic          tx_en_cmd,
  input  logic          tx_dis_cmd,
  input  logic          brk_pend,
  output logic          txd,
  output logic          txrdy,
  output logic          txempty
);
  logic          en_q, en_n, wr_ok, take, idle_n;
  logic          hold_full, hold_full_n;
  logic [DW-1:0] hold_data;
  fr_state_e     fr_state;

  assign en_n  = tx_dis_cmd ? 1'b0 : (tx_en_cmd ? 1'b1 : en_q);
  assign wr_ok = wr_valid && txrdy && !tx_dis_cmd;

  txg_hold #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .dis      (tx_dis_cmd),
    .wr_ok    (wr_ok),
    .wr_data  (wr_data),
    .len_code (len_code),
    .take     (take),
    .full_q   (hold_full),
    .full_n   (hold_full_n),
    .data_q   (hold_data)
  );

  txg_framer #(.DW(DW), .GW(GW)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .dis       (tx_dis_cmd),
    .tick      (bit_tick),
    .en_q      (en_q),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .len_code  (len_code),
    .par_mode  (par_mode),
    .guard     (guard_len),
    .take      (take),
    .idle_n    (idle_n),
    .txd_q     (txd),
    .state_q   (fr_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      txrdy   <= 1'b0;
      txempty <= 1'b0;
    end else begin
      en_q    <= en_n;
      txrdy   <= en_n && !hold_full_n && !brk_pend;
      txempty <= en_n && !hold_full_n && idle_n;
    end
  end
endmodule

// File: rtl/txg_chk.sv
module txg_chk
  import txg_pkg::*;
#(
  parameter int DW = TXG_DW
) (
  input logic          clk,
  input logic          rst,
  input logic          txd,
  input logic          txrdy,
  input logic          txempty,
  input logic          wr_valid,
  input logic          tx_en_cmd,
  input logic          tx_dis_cmd,
  input logic          brk_pend,
  input logic          en_q,
  input logic          hold_full,
  input logic [DW-1:0] hold_data,
  input logic [2:0]    fr_state
);
  p_empty_line_high_r6: assert property (@(posedge clk) disable iff (rst)
    txempty |-> txd);

  p_busy_not_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (fr_state != 3'(FR_IDLE)) |-> !txempty);

  p_full_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    hold_full |-> !txrdy);

  p_drop_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !txrdy && hold_full && !tx_dis_cmd) |=> $stable(hold_data));

  p_disable_r9: assert property (@(posedge clk) disable iff (rst)
    tx_dis_cmd |=> (!txrdy && !txempty && txd));

  p_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_en_cmd && !tx_dis_cmd && !en_q && !brk_pend) |=> (txrdy && txempty));

  p_guard_high_r5: assert property (@(posedge clk) disable iff (rst)
    (fr_state == 3'(FR_GUARD)) |-> txd);
endmodule

bind guarded_uart_tx txg_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .txd        (txd),
  .txrdy      (txrdy),
  .txempty    (txempty),
  .wr_valid   (wr_valid),
  .tx_en_cmd  (tx_en_cmd),
  .tx_dis_cmd (tx_dis_cmd),
  .brk_pend   (brk_pend),
  .en_q       (en_q),
  .hold_full  (hold_full),
  .hold_data  (hold_data),
  .fr_state   (fr_state)
);

// File: tb/guarded_uart_tx_tb.sv
`timescale 1ns/1ps
module guarded_uart_tx_tb;
  localparam int DIV = 8;
  localparam int NV  = 6;
  // {has_par, par_bit, nbits[3:0], guard[7:0], par_mode[1:0], len_code[1:0], data[7:0]}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd8, 8'd0, 2'b00, 2'd3, 8'hA5},
    {1'b1, 1'b0, 4'd8, 8'd2, 2'b01, 2'd3, 8'h3C},
    {1'b1, 1'b1, 4'd8, 8'd0, 2'b10, 2'd3, 8'h3C},
    {1'b1, 1'b1, 4'd5, 8'd1, 2'b01, 2'd0, 8'hFF},
    {1'b0, 1'b0, 4'd6, 8'd3, 2'b11, 2'd1, 8'h5A},
    {1'b1, 1'b0, 4'd7, 8'd0, 2'b10, 2'd2, 8'h81}
  };

  logic clk = 0, rst = 1, bit_tick = 0, wr_valid = 0;
  logic [7:0] wr_data = 0, guard_len = 0;
  logic [1:0] len_code = 3, par_mode = 0;
  logic tx_en_cmd = 0, tx_dis_cmd = 0, brk_pend = 0;
  logic txd, txrdy, txempty;
  int checks = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  guarded_uart_tx u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_valid(wr_valid),
    .wr_data(wr_data), .len_code(len_code), .par_mode(par_mode),
    .guard_len(guard_len), .tx_en_cmd(tx_en_cmd), .tx_dis_cmd(tx_dis_cmd),
    .brk_pend(brk_pend), .txd(txd), .txrdy(txrdy), .txempty(txempty)
  );

  initial begin
    forever begin
      repeat (DIV - 1) @(negedge clk);
      bit_tick = 1;
      @(negedge clk);
      bit_tick = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic next_bit();
    step();
    while (!bit_tick) step();
    step();
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    step();
    while (txd !== 1'b0 && n < 200) begin
      step();
      n++;
    end
    chk(req, {31'd0, txd}, 32'd0);
  endtask

  task automatic check_rest(input logic [7:0] d, input int nb, input bit hp, input bit pb,
                            input int g, input bit chain, input string dreq);
    int cnt;
    for (int i = 0; i < nb; i++) begin
      next_bit();
      chk(dreq, {31'd0, txd}, {31'd0, d[i]});
    end
    if (hp) begin
      next_bit();
      chk("R4 parity bit", {31'd0, txd}, {31'd0, pb});
    end
    next_bit();
    chk("R5 stop bit", {31'd0, txd}, 32'd1);
    chk("R6 busy during stop", {31'd0, txempty}, 32'd0);
    if (chain) begin
      next_bit();
      chk("R11 back-to-back start", {31'd0, txd}, 32'd0);
    end else begin
      cnt = 0;
      while (cnt < 300) begin
        next_bit();
        cnt++;
        if (txempty) break;
        chk("R5 guard line high", {31'd0, txd}, 32'd1);
      end
      chk("R6 empty after guard", cnt, g + 1);
    end
  endtask

  initial begin
    repeat (3) step();
    chk("R1 txd in reset", {31'd0, txd}, 32'd1);
    @(negedge clk);
    rst = 0;
    step();
    step();
    chk("R1 txd after reset", {31'd0, txd}, 32'd1);
    chk("R1 txrdy after reset", {31'd0, txrdy}, 32'd0);
    chk("R1 txempty after reset", {31'd0, txempty}, 32'd0);

    @(negedge clk);
    tx_en_cmd = 1;
    @(negedge clk);
    tx_en_cmd = 0;
    #1;
    chk("R2 txrdy on enable", {31'd0, txrdy}, 32'd1);
    chk("R2 txempty on enable", {31'd0, txempty}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      guard_len = VEC[v][19:12];
      par_mode  = VEC[v][11:10];
      len_code  = VEC[v][9:8];
      wr(VEC[v][7:0]);
      wait_start("R3 start bit");
      check_rest(VEC[v][7:0], int'(VEC[v][23:20]), VEC[v][25], VEC[v][24],
                 int'(VEC[v][19:12]), 1'b0, (v == 3) ? "R10 low bits" : "R3 data bit");
    end

    @(negedge clk);
    guard_len = 0;
    par_mode  = 0;
    len_code  = 3;
    wr(8'h96);
    wait_start("R3 start bit A");
    wr(8'h4B);
    wr(8'hFF);
    step();
    chk("R7 txrdy with held char", {31'd0, txrdy}, 32'd0);
    chk("R6 txempty with held char", {31'd0, txempty}, 32'd0);
    check_rest(8'h96, 8, 1'b0, 1'b0, 0, 1'b1, "R3 data bit A");
    check_rest(8'h4B, 8, 1'b0, 1'b0, 0, 1'b0, "R11 data bit B");
    for (int k = 0; k < 3; k++) begin
      next_bit();
      chk("R8 refused char not sent", {31'd0, txd}, 32'd1);
      chk("R8 line stays empty", {31'd0, txempty}, 32'd1);
    end

    @(negedge clk);
    brk_pend = 1;
    step();
    chk("R7 txrdy low on break", {31'd0, txrdy}, 32'd0);
    wr(8'h00);
    for (int k = 0; k < 2; k++) begin
      next_bit();
      chk("R8 write during break dropped", {31'd0, txd}, 32'd1);
      chk("R8 empty during break", {31'd0, txempty}, 32'd1);
    end
    @(negedge clk);
    brk_pend = 0;
    step();
    chk("R7 txrdy back after break", {31'd0, txrdy}, 32'd1);

    wr(8'h00);
    wait_start("R3 start before disable");
    @(negedge clk);
    tx_dis_cmd = 1;
    @(negedge clk);
    tx_dis_cmd = 0;
    #1;
    chk("R9 txd after disable", {31'd0, txd}, 32'd1);
    chk("R9 txrdy after disable", {31'd0, txrdy}, 32'd0);
    chk("R9 txempty after disable", {31'd0, txempty}, 32'd0);
    for (int k = 0; k < 2; k++) begin
      next_bit();
      chk("R9 line idle while disabled", {31'd0, txd}, 32'd1);
    end
    @(negedge clk);
    tx_en_cmd  = 1;
    tx_dis_cmd = 1;
    @(negedge clk);
    tx_en_cmd  = 0;
    tx_dis_cmd = 0;
    #1;
    chk("R9 disable wins over enable", {31'd0, txrdy}, 32'd0);
    @(negedge clk);
    tx_en_cmd = 1;
    @(negedge clk);
    tx_en_cmd = 0;
    #1;
    chk("R2 re-enable txrdy", {31'd0, txrdy}, 32'd1);
    chk("R2 re-enable txempty", {31'd0, txempty}, 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end
endmodule